// File: doc/BRIEF.md
# Digital Potentiometer Wiper Register Controller

This block is the register and control core of a 1024-tap digital potentiometer. It keeps a volatile 10-bit wiper code, which chooses the active tap, and a bank of four 10-bit data registers that stand in for nonvolatile storage. A host drives a parallel command port that has a 3-bit opcode, a 2-bit register index, a 10-bit write value and a one-cycle valid strobe. Read results come back on a 10-bit bus with a one-cycle valid pulse. The wiper code is also decoded into a one-hot tap enable vector that drives the switch array.

The wiper can be set in three ways. The host can write it directly. It can be copied from any data register. It is also reloaded from data register 0 every time reset is applied, which models power-up. The data registers are not cleared by reset, so their contents survive a power cycle. The wiper does not survive. Every command that changes a data register starts a timer that models the nonvolatile write time. While the timer runs, the busy output is high and every further command is refused, and each refusal raises an error pulse. When only one wiper setting needs storing, the data registers can serve as general-purpose storage.

Top module: `dpot_core`

## Requirements
- R1: On each clock edge with `rst_n` low, the wiper loads the current value of data register 0, `busy` clears, and `rd_valid` and `cmd_err` are 0. Data register contents are kept across reset.
- R2: An accepted opcode 1 (write wiper) makes `wiper_code` equal `cmd_wdata` in the cycle after the strobe.
- R3: `tap_sel` always has exactly one bit set, and that bit's index equals `wiper_code`.
- R4: An accepted opcode 0 (read wiper) gives `rd_valid` high for one cycle in the next cycle, with `rd_data` equal to the wiper code at the strobe. Reads issued on back-to-back cycles give back-to-back pulses.
- R5: An accepted opcode 3 (write data register) stores `cmd_wdata` into the register that `cmd_sel` selects, where values 0 to 3 address registers 0 to 3.
- R6: An accepted opcode 2 (read data register) returns the contents of the register that `cmd_sel` selects, with the same timing as R4.
- R7: An accepted opcode 4 (data register to wiper) loads the selected register into the wiper in the next cycle and does not raise `busy`.
- R8: An accepted opcode 5 (wiper to data register) stores the current wiper code into the selected data register.
- R9: After an accepted opcode 3 or 5, `busy` is high for exactly NV_CYCLES = CYCLES_PER_MS × NV_WRITE_MS cycles, starting the cycle after the strobe. A command issued in the last busy cycle is still refused.
- R10: A strobe while `busy` is high changes neither the wiper nor any data register, produces no read pulse, and gives a one-cycle `cmd_err` pulse in the next cycle.
- R11: Opcodes 6 and 7, when issued while idle, have no effect and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (models power-up) |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Opcode: 0 rd wiper, 1 wr wiper, 2 rd reg, 3 wr reg, 4 reg→wiper, 5 wiper→reg |
| cmd_sel | input | 2 | Data register index |
| cmd_wdata | input | 10 | Write value for opcodes 1 and 3 |
| wiper_code | output | 10 | Current wiper position |
| tap_sel | output | 1024 | One-hot tap switch enables |
| rd_valid | output | 1 | Read result valid pulse |
| rd_data | output | 10 | Read result |
| busy | output | 1 | Nonvolatile write in progress |
| cmd_err | output | 1 | Pulse: command refused because busy |

## Verification
Every clock cycle, a behavioural model in the bench is compared against the wiper, the tap vector, the read channel, busy and the error pulse. The wiper is written with all-zeros, all-ones, alternating-bit and mid-scale codes, which separates bit-order or truncation faults in both the register and the tap decoder. Each data register is written with a different pattern and then copied into the wiper, which exposes index mix-ups between the four registers. Every opcode is issued during a busy window, including in its last cycle, and reset is applied with the wiper changed and with a write in progress. This separates correct refusal, timer length and reload from register 0 from their near-miss variants.

// File: rtl/dpot_pkg.sv
// Package: shared opcode encoding and decoded-command type for the
// potentiometer register core. Assumes a 3-bit opcode field.
package dpot_pkg;

    typedef enum logic [2:0] {
        OP_RD_WIPER    = 3'd0,
        OP_WR_WIPER    = 3'd1,
        OP_RD_DR       = 3'd2,
        OP_WR_DR       = 3'd3,
        OP_DR_TO_WIPER = 3'd4,
        OP_WIPER_TO_DR = 3'd5,
        OP_RSVD6       = 3'd6,
        OP_RSVD7       = 3'd7
    } op_e;

    // One strobe per accepted operation; at most one is set per cycle.
    typedef struct packed {
        logic rd_wiper;
        logic wr_wiper;
        logic rd_dr;
        logic wr_dr;
        logic dr_to_wiper;
        logic wiper_to_dr;
    } cmd_dec_t;

endpackage

// File: rtl/dpot_cmd_ctrl.sv
// Module: dpot_cmd_ctrl
// Turns a command strobe into one accepted-operation strobe, or refuses
// it while a nonvolatile write is running and flags the refusal one cycle
// later. Assumes: cmd_valid is a single-cycle strobe; reserved opcodes are
// silently dropped while idle; nothing is accepted during reset.
module dpot_cmd_ctrl
    import dpot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic     nv_busy,
    output cmd_dec_t dec,
    output logic     cmd_err
);

    logic accept;
    logic refuse;

    // Purpose: decide whether this strobe is taken or refused.
    always_comb begin
        accept = cmd_valid && rst_n && !nv_busy;
        refuse = cmd_valid && rst_n && nv_busy;
    end

    // Purpose: map an accepted opcode onto its single operation strobe.
    always_comb begin
        dec = '0;
        if (accept) begin
            case (op_e'(cmd_op))
                OP_RD_WIPER:    dec.rd_wiper    = 1'b1;
                OP_WR_WIPER:    dec.wr_wiper    = 1'b1;
                OP_RD_DR:       dec.rd_dr       = 1'b1;
                OP_WR_DR:       dec.wr_dr       = 1'b1;
                OP_DR_TO_WIPER: dec.dr_to_wiper = 1'b1;
                OP_WIPER_TO_DR: dec.wiper_to_dr = 1'b1;
                default:        dec             = '0;
            endcase
        end
    end

    // Purpose: register the refusal into a one-cycle error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_err <= 1'b0;
        end else begin
            cmd_err <= refuse;
        end
    end

    AST_ONE_OP_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec)) else $error("more than one op strobe"); // R10

    AST_REFUSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && nv_busy) |=> cmd_err) else $error("refusal not flagged"); // R10

endmodule

// File: rtl/dpot_nv_timer.sv
// Module: dpot_nv_timer
// Models the nonvolatile write time: a start pulse raises busy for exactly
// CYCLES clock cycles. Assumes CYCLES >= 1 and that start never arrives
// while busy (the command controller guarantees this). Reset aborts a run.
module dpot_nv_timer #(
    parameter int CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CNT_W-1:0] remain_q;

    // Purpose: load the countdown on start, count down, drop busy at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain_q <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            remain_q <= CNT_W'(CYCLES - 1);
        end else if (busy) begin
            if (remain_q == '0) begin
                busy <= 1'b0;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    AST_BUSY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy) else $error("busy did not rise"); // R9

    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && remain_q == '0 && !start) |=> !busy) else $error("busy overran"); // R9

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start) else $error("restart while busy"); // R10

endmodule

// File: rtl/dpot_dr_bank.sv
// Module: dpot_dr_bank
// Bank of NUM_DR data registers standing in for nonvolatile cells. There is
// deliberately no reset: contents persist through a power-up reset. One
// write port and one read port, plus a dedicated tap of register 0 for the
// power-up wiper reload. Assumes NUM_DR is a power of two.
module dpot_dr_bank #(
    parameter int WIDTH  = 10,
    parameter int NUM_DR = 4,
    localparam int SEL_W = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] dr0
);

    logic [WIDTH-1:0] regs [NUM_DR];

    for (genvar g = 0; g < NUM_DR; g++) begin : g_cell
        // Purpose: update this cell when the write port addresses it.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == SEL_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    // Purpose: combinational read of the addressed cell and of cell 0.
    always_comb begin
        rd_data = regs[rd_sel];
        dr0     = regs[0];
    end

endmodule

// File: rtl/dpot_tap_decode.sv
// Module: dpot_tap_decode
// Decodes the wiper code into a one-hot vector of 2**WIDTH tap enables.
// Assumes every code value is a legal tap (no unused codes).
module dpot_tap_decode #(
    parameter int WIDTH = 10,
    localparam int TAPS = 1 << WIDTH
) (
    input  logic [WIDTH-1:0] code,
    output logic [TAPS-1:0]  taps
);

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        // Purpose: enable switch t only when the code selects it.
        assign taps[t] = (code == WIDTH'(t));
    end

endmodule

// File: rtl/dpot_core.sv
// Module: dpot_core (top)
// Register and control core of a digital potentiometer: volatile wiper
// register, nonvolatile-modelled data register bank, six-operation command
// port, one-hot tap output and a busy timer for data-register writes.
// Assumes: rst_n models power-up and reloads the wiper from register 0;
// data register updates commit at the accepting edge, busy only models time.
module dpot_core
    import dpot_pkg::*;
#(
    parameter int WIPER_W       = 10,
    parameter int NUM_DR        = 4,
    parameter int CYCLES_PER_MS = 1000,
    parameter int NV_WRITE_MS   = 10,
    localparam int SEL_W        = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
    localparam int TAPS         = 1 << WIPER_W,
    localparam int NV_CYCLES    = CYCLES_PER_MS * NV_WRITE_MS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [SEL_W-1:0]   cmd_sel,
    input  logic [WIPER_W-1:0] cmd_wdata,
    output logic [WIPER_W-1:0] wiper_code,
    output logic [TAPS-1:0]    tap_sel,
    output logic               rd_valid,
    output logic [WIPER_W-1:0] rd_data,
    output logic               busy,
    output logic               cmd_err
);

    cmd_dec_t           dec;
    logic [WIPER_W-1:0] wiper_q;
    logic [WIPER_W-1:0] dr_rd;
    logic [WIPER_W-1:0] dr0;
    logic               dr_wr_en;
    logic [WIPER_W-1:0] dr_wr_data;

    dpot_cmd_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .nv_busy  (busy),
        .dec      (dec),
        .cmd_err  (cmd_err)
    );

    // Purpose: choose the data register write source (host or wiper).
    always_comb begin
        dr_wr_en   = dec.wr_dr || dec.wiper_to_dr;
        dr_wr_data = dec.wr_dr ? cmd_wdata : wiper_q;
    end

    dpot_dr_bank #(
        .WIDTH (WIPER_W),
        .NUM_DR(NUM_DR)
    ) u_bank (
        .clk    (clk),
        .wr_en  (dr_wr_en),
        .wr_sel (cmd_sel),
        .wr_data(dr_wr_data),
        .rd_sel (cmd_sel),
        .rd_data(dr_rd),
        .dr0    (dr0)
    );

    dpot_nv_timer #(
        .CYCLES(NV_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(dr_wr_en),
        .busy (busy)
    );

    // Purpose: wiper register with power-up reload, host write and copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper_q <= dr0;
        end else if (dec.wr_wiper) begin
            wiper_q <= cmd_wdata;
        end else if (dec.dr_to_wiper) begin
            wiper_q <= dr_rd;
        end
    end

    // Purpose: registered read channel for wiper and data register reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= dec.rd_wiper || dec.rd_dr;
            if (dec.rd_wiper) begin
                rd_data <= wiper_q;
            end else if (dec.rd_dr) begin
                rd_data <= dr_rd;
            end
        end
    end

    dpot_tap_decode #(
        .WIDTH(WIPER_W)
    ) u_taps (
        .code(wiper_q),
        .taps(tap_sel)
    );

    assign wiper_code = wiper_q;

    AST_TAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_sel[wiper_q] && $countones(tap_sel) == 1)) else $error("tap mismatch"); // R3

    AST_WIPER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 3'(OP_WR_WIPER)) |=> (wiper_q == $past(cmd_wdata)))
        else $error("wiper write lost"); // R2

    AST_WIPER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 3'(OP_RD_WIPER)) |=> (rd_valid && rd_data == $past(wiper_q)))
        else $error("wiper read wrong"); // R4

    AST_COPY_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 3'(OP_DR_TO_WIPER)) |=> (wiper_q == $past(dr_rd) && !busy))
        else $error("copy to wiper wrong"); // R7

    AST_REFUSED_KEEPS_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> (wiper_q == $past(wiper_q) && !rd_valid))
        else $error("refused command acted"); // R10

endmodule

// File: tb/tb_dpot_core.sv
// Bench for dpot_core: a behavioural model kept in integers is advanced on
// every rising edge and compared with all outputs on every falling edge.
module tb_dpot_core;

    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 3;
    localparam int NVMS       = 10;
    localparam int NV         = CPM * NVMS;
    localparam int W          = 10;
    localparam int NDR        = 4;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [1:0]    cmd_sel = '0;
    logic [W-1:0]  cmd_wdata = '0;
    logic [W-1:0]  wiper_code;
    logic [1023:0] tap_sel;
    logic          rd_valid;
    logic [W-1:0]  rd_data;
    logic          busy;
    logic          cmd_err;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // model state
    int m_wiper = 0;
    bit m_wiper_known = 1'b0;
    int m_dr [NDR];
    bit m_dr_known [NDR];
    int m_cnt = 0;
    bit m_rdv = 1'b0;
    int m_rdd = 0;
    bit m_rdd_known = 1'b0;
    bit m_err = 1'b0;

    dpot_core #(
        .WIPER_W      (W),
        .NUM_DR       (NDR),
        .CYCLES_PER_MS(CPM),
        .NV_WRITE_MS  (NVMS)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_sel   (cmd_sel),
        .cmd_wdata (cmd_wdata),
        .wiper_code(wiper_code),
        .tap_sel   (tap_sel),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .busy      (busy),
        .cmd_err   (cmd_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        for (int i = 0; i < NDR; i++) begin
            m_dr[i] = 0;
            m_dr_known[i] = 1'b0;
        end
    end

    // Reference model: advance on each rising edge from the requirements.
    always @(posedge clk) begin
        bit was_busy;
        was_busy = (m_cnt > 0);
        if (!rst_n) begin
            // R1: reload from register 0, clear timer and pulses
            m_wiper = m_dr[0];
            m_wiper_known = m_dr_known[0];
            m_cnt = 0;
            m_rdv = 1'b0;
            m_rdd = 0;
            m_rdd_known = 1'b1;
            m_err = 1'b0;
        end else begin
            bit start;
            start = 1'b0;
            m_rdv = 1'b0;
            m_err = 1'b0;
            if (cmd_valid && was_busy) begin
                m_err = 1'b1; // R10
            end else if (cmd_valid) begin
                case (int'(cmd_op))
                    0: begin m_rdv = 1'b1; m_rdd = m_wiper; m_rdd_known = m_wiper_known; end
                    1: begin m_wiper = int'(cmd_wdata); m_wiper_known = 1'b1; end
                    2: begin m_rdv = 1'b1; m_rdd = m_dr[cmd_sel]; m_rdd_known = m_dr_known[cmd_sel]; end
                    3: begin m_dr[cmd_sel] = int'(cmd_wdata); m_dr_known[cmd_sel] = 1'b1; start = 1'b1; end
                    4: begin m_wiper = m_dr[cmd_sel]; m_wiper_known = m_dr_known[cmd_sel]; end
                    5: begin m_dr[cmd_sel] = m_wiper; m_dr_known[cmd_sel] = m_wiper_known; start = 1'b1; end
                    default: ; // R11: reserved opcodes do nothing
                endcase
            end
            if (start) m_cnt = NV;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare on every falling edge.
    always @(negedge clk) begin
        check("R9/R10 busy", int'(busy), int'(m_cnt > 0));
        check("R10/R11 cmd_err", int'(cmd_err), int'(m_err));
        check("R4/R6 rd_valid", int'(rd_valid), int'(m_rdv));
        if (m_rdv && m_rdd_known) check("R4/R6 rd_data", int'(rd_data), m_rdd);
        if (m_wiper_known) begin
            check("R1/R2/R7 wiper_code", int'(wiper_code), m_wiper);
            check("R3 tap_sel", int'(tap_sel[m_wiper] && $countones(tap_sel) == 1), 1);
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic issue(input int op, input int sel, input int data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_sel   = 2'(sel);
        cmd_wdata = W'(data);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_nv();
        idle(NV + 2);
    endtask

    initial begin
        int pats [5];
        int drv [4];
        pats = '{0, 1023, 341, 682, 512};
        drv  = '{677, 346, 1023, 0};

        // R1: reset state
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R5, R9: write each data register, busy for the full window
        for (int i = 0; i < NDR; i++) begin
            issue(3, i, drv[i]);
            wait_nv();
        end
        // R6: read each data register back
        for (int i = 0; i < NDR; i++) issue(2, i, 0);

        // R2, R3, R4: host wiper writes with several code patterns
        for (int i = 0; i < 5; i++) begin
            issue(1, 0, pats[i]);
            issue(0, 0, 0);
        end
        // R4: back-to-back reads
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0;
        @(negedge clk);
        cmd_op = 3'd2; cmd_sel = 2'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        idle(2);

        // R7: copy each data register into the wiper, no busy
        for (int i = 0; i < NDR; i++) begin
            issue(4, i, 0);
            issue(0, 0, 0);
        end

        // R8: copy the wiper into register 2
        issue(1, 0, 240);
        issue(5, 2, 0);
        wait_nv();
        issue(2, 2, 0);

        // R10: every opcode refused while busy, including the last busy cycle
        issue(3, 1, 85);
        for (int op = 0; op < 8; op++) issue(op, 1, 1000 - op);
        idle(NV - 18);
        issue(1, 0, 999); // strobe lands on the final busy edge
        idle(3);
        issue(2, 1, 0);
        issue(0, 0, 0);

        // R11: reserved opcodes while idle
        issue(6, 3, 111);
        issue(7, 0, 222);
        issue(0, 0, 0);
        issue(2, 3, 0);

        // R1: power-up reload from register 0, registers retained
        issue(1, 0, 273);
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);
        for (int i = 0; i < NDR; i++) issue(2, i, 0);

        // R1, R9: reset during a busy window aborts busy, write kept
        issue(3, 0, 100);
        idle(5);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);
        issue(2, 0, 0);
        issue(0, 0, 0);
        idle(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule